// File: doc/BRIEF.md
# SPI master channel with register interface

This block is one SPI master channel controlled through a small set of memory-mapped registers. Software programs a configuration word (clock phase and polarity, serial-clock divider, word length from 4 to 32 bits, chip-select level, transfer direction, DMA request enables), sets the channel enable and then exchanges words through a transmit register and a receive register. Each word is sent most significant bit first. The transmit word is taken from the low bits of the register, and the received word is placed in the low bits of the receive register. Chip select is held active by a force bit, which software sets and clears on its own, apart from the channel enable. A status register reports receive-full, transmit-empty and end-of-transfer. Two request lines tell a DMA engine when the transmit register can take a word and when the receive register holds one.

Besides full duplex, the channel has a receive-only mode and a transmit-only mode. In receive-only mode one write to the transmit register starts the first word, and each read of the receive register starts the next one. Software switches back to full duplex before its last read so that no extra word is clocked. In transmit-only mode the received bits are thrown away. A soft reset returns every register to its reset value, and a reset-done flag shows when the reset has finished.

Register accesses are single-cycle. A write takes effect at the clock edge where `reg_en` and `reg_we` are high. Read data is valid in the same cycle as the request. The side effects of a read (clearing receive-full, starting a receive-only word) take place at that clock edge. The bus has no back-pressure: every access completes at once.

Top module: `spim_channel`

## Requirements
- R1: After reset, the status register reads 0x6, system-status reads 0x1, the configuration register reads 0, and sclk, cs_out, dma_tx_req and dma_rx_req are all 0.
- R2: Configuration bits 11:7 hold the word length minus one, for lengths 4 to 32. A full-duplex word shifts the low bits of the TX word out on mosi, MSB first. The receive register then holds the bits taken from miso, MSB first, placed in its low bits, with the upper bits zero.
- R3: Configuration bit 1 is the polarity and sets the idle level of sclk. Bit 0 is the phase: with phase 0, data is sampled on the leading edge and changed on the trailing edge; with phase 1, data is changed on the leading edge and sampled on the trailing edge. A word of length L makes exactly 2L sclk transitions and leaves sclk at its idle level.
- R4: Configuration bits 5:2 hold an exponent N from 0 to 15. Each half-period of sclk lasts 2^N clock cycles.
- R5: Status bit 0 (receive-full) is set when a word completes in full-duplex or receive-only mode and is cleared by a read of RX. Status bit 1 (transmit-empty) is cleared by a write to TX and set when the word is loaded into the shifter. Status bit 2 (end of transfer) is 1 when the shifter is idle and transmit-empty is set.
- R6: Control bit 0 enables the channel. While it is 0, sclk makes no transition and a word written to TX stays pending, with transmit-empty still 0.
- R7: In transmit-only mode (bits 13:12 = 2), a completed word leaves receive-full at 0 and the receive register unchanged.
- R8: In receive-only mode (bits 13:12 = 1), a write to TX starts the first word and each read of RX starts one more word. If the mode is changed to full duplex (bits 13:12 = 0) before the read, that read starts no word.
- R9: cs_out is at its active level while configuration bit 20 is set, and inactive otherwise. The active level is low when bit 6 is set and high when it is clear.
- R10: dma_tx_req is high when configuration bit 14 and transmit-empty are both set. dma_rx_req is high when configuration bit 15 and receive-full are both set.
- R11: Writing 1 to bit 1 of system-config (0x10) makes system-status bit 0 (0x14) read 0 for one cycle. After that cycle every register is back at its reset value and the flag reads 1.
- R12: The registers sit at 0x2C configuration, 0x30 status, 0x34 control, 0x38 TX, 0x3C RX, 0x10 system-config and 0x14 system-status. Configuration bits 20:0 read back as written, with bits 31:21 read as 0. Offsets that hold no register read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the request cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_out | output | 1 | Chip select |
| dma_tx_req | output | 1 | DMA request: TX register can take a word |
| dma_rx_req | output | 1 | DMA request: RX register holds a word |

## Verification
The bench builds the block with its default parameters: a 32-bit maximum word and a 4-bit divider exponent. This allows words from 4 up to the full 32 bits. A table of six words covers all four clock modes, several word lengths and divider exponents from 0 to 3, and a slave model in the bench checks both directions of data and the spacing of the sclk edges. Directed cases then cover the pending word while the channel is disabled, both DMA requests, the transmit-only and receive-only sequences (including the switch back to full duplex before the last read), chip-select polarity and the soft-reset window.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int ADDR_W = 8;
  localparam int CFG_W  = 21;

  localparam logic [ADDR_W-1:0] OFS_SYSCFG  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_SYSSTAT = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CFG     = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_STAT    = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_TXD     = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_RXD     = 8'h3C;

  typedef enum logic [1:0] {
    XFER_DUPLEX  = 2'd0,
    XFER_RX_ONLY = 2'd1,
    XFER_TX_ONLY = 2'd2,
    XFER_RSVD    = 2'd3
  } xfer_mode_e;

  // Field positions are software-visible and fixed.
  typedef struct packed {
    logic       force_cs;   // 20
    logic [3:0] spare;      // 19:16
    logic       dma_rd_en;  // 15
    logic       dma_wr_en;  // 14
    xfer_mode_e mode;       // 13:12
    logic [4:0] wlen_m1;    // 11:7
    logic       cs_low;     // 6
    logic [3:0] div_exp;    // 5:2
    logic       cpol;       // 1
    logic       cpha;       // 0
  } chan_cfg_t;
endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [EXP_W-1:0] div_exp,
  output logic             tick
);
  localparam int CNT_W = (1 << EXP_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] one;

  assign one   = {{(CNT_W-1){1'b0}}, 1'b1};
  // At the top exponent the shift wraps to zero, so the limit becomes all ones.
  assign limit = (one << div_exp) - one;
  assign tick  = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (clr || !run || tick)  cnt <= '0;
    else                           cnt <= cnt + one;
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int MAXW  = 32,
  parameter int EXP_W = 4,
  localparam int LEN_W = $clog2(MAXW),
  localparam int HC_W  = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             start,
  input  logic [MAXW-1:0]  tx_word,
  input  logic [LEN_W-1:0] wlen_m1,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [EXP_W-1:0] div_exp,
  input  logic             miso,
  output logic             busy,
  output logic             done,
  output logic [MAXW-1:0]  rx_word,
  output logic             sclk,
  output logic             mosi
);
  logic            tick;
  logic [HC_W-1:0] hcnt;
  logic            sclk_ph;
  logic [MAXW-1:0] txsh, rxsh, rx_shift;
  logic            last_half, sample_now, drive_now;

  spim_clkgen #(.EXP_W(EXP_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run(busy && en),
    .div_exp(div_exp), .tick(tick)
  );

  // Even half-counts are leading edges, odd ones trailing.
  assign last_half  = (hcnt == {wlen_m1, 1'b1});
  assign sample_now = tick && (cpha ? hcnt[0] : !hcnt[0]);
  assign drive_now  = tick && (cpha ? (!hcnt[0] && (hcnt != '0)) : hcnt[0]);
  assign rx_shift   = {rxsh[MAXW-2:0], miso};
  assign rx_word    = sample_now ? rx_shift : rxsh;
  assign done       = tick && last_half;
  assign sclk       = cpol ^ sclk_ph;
  assign mosi       = txsh[wlen_m1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; hcnt <= '0; sclk_ph <= 1'b0; txsh <= '0; rxsh <= '0;
    end else if (clr) begin
      busy <= 1'b0; hcnt <= '0; sclk_ph <= 1'b0; txsh <= '0; rxsh <= '0;
    end else if (start) begin
      busy <= 1'b1; hcnt <= '0; sclk_ph <= 1'b0; txsh <= tx_word; rxsh <= '0;
    end else if (tick) begin
      sclk_ph <= ~sclk_ph;
      if (sample_now) rxsh <= rx_shift;
      if (drive_now)  txsh <= {txsh[MAXW-2:0], 1'b0};
      if (last_half)  busy <= 1'b0;
      else            hcnt <= hcnt + 1'b1;
    end
  end

  // R6: with the channel disabled the word in flight is frozen.
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr && !start) |=> ($stable(hcnt) && $stable(sclk_ph)));
endmodule

// File: rtl/spim_channel.sv
module spim_channel
  import spim_pkg::*;
#(
  parameter int MAXW  = 32,
  parameter int EXP_W = 4,
  localparam int LEN_W = $clog2(MAXW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_out,
  output logic              dma_tx_req,
  output logic              dma_rx_req
);
  chan_cfg_t       cfg;
  logic            ctrl_en, tx_empty, rx_full, srst, rx_kick;
  logic [MAXW-1:0] tx_data, rx_data, rx_word;
  logic            busy, done, start, eot;
  logic            wr, rd, wr_tx, rd_rx, wr_srst, want_word;

  assign wr      = reg_en && reg_we;
  assign rd      = reg_en && !reg_we;
  assign wr_tx   = wr && (reg_addr == OFS_TXD);
  assign rd_rx   = rd && (reg_addr == OFS_RXD);
  assign wr_srst = wr && (reg_addr == OFS_SYSCFG) && reg_wdata[1];

  assign want_word = (cfg.mode == XFER_RX_ONLY) ? (rx_kick || !tx_empty) : !tx_empty;
  assign start     = ctrl_en && !busy && !srst && want_word;
  assign eot       = !busy && tx_empty;

  spim_shifter #(.MAXW(MAXW), .EXP_W(EXP_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(srst), .en(ctrl_en), .start(start),
    .tx_word(tx_data), .wlen_m1(cfg.wlen_m1[LEN_W-1:0]), .cpol(cfg.cpol),
    .cpha(cfg.cpha), .div_exp(cfg.div_exp), .miso(miso), .busy(busy),
    .done(done), .rx_word(rx_word), .sclk(sclk), .mosi(mosi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srst <= 1'b0;
    else        srst <= wr_srst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0; ctrl_en <= 1'b0; tx_data <= '0; rx_data <= '0;
      tx_empty <= 1'b1; rx_full <= 1'b0; rx_kick <= 1'b0;
    end else if (srst) begin
      cfg <= '0; ctrl_en <= 1'b0; tx_data <= '0; rx_data <= '0;
      tx_empty <= 1'b1; rx_full <= 1'b0; rx_kick <= 1'b0;
    end else begin
      if (wr && reg_addr == OFS_CFG)  cfg <= chan_cfg_t'(reg_wdata[CFG_W-1:0]);
      if (wr && reg_addr == OFS_CTRL) ctrl_en <= reg_wdata[0];
      if (wr_tx) begin
        tx_data  <= reg_wdata[MAXW-1:0];
        tx_empty <= 1'b0;
      end else if (start) begin
        tx_empty <= 1'b1;
      end
      if (done && cfg.mode != XFER_TX_ONLY) begin
        rx_data <= rx_word;
        rx_full <= 1'b1;
      end else if (rd_rx) begin
        rx_full <= 1'b0;
      end
      if (rd_rx && cfg.mode == XFER_RX_ONLY) rx_kick <= 1'b1;
      else if (start)                        rx_kick <= 1'b0;
    end
  end

  assign cs_out     = cfg.force_cs ^ cfg.cs_low;
  assign dma_tx_req = cfg.dma_wr_en && tx_empty;
  assign dma_rx_req = cfg.dma_rd_en && rx_full;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_SYSSTAT: reg_rdata = {31'b0, !srst};
      OFS_CFG:     reg_rdata = {{(32-CFG_W){1'b0}}, cfg};
      OFS_STAT:    reg_rdata = {29'b0, eot, tx_empty, rx_full};
      OFS_CTRL:    reg_rdata = {31'b0, ctrl_en};
      OFS_TXD:     reg_rdata = 32'(tx_data);
      OFS_RXD:     reg_rdata = 32'(rx_data);
      default:     reg_rdata = '0;
    endcase
  end

  // R7: receive-full never rises from a transmit-only word.
  a_r7_txonly_no_rxfull: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> ($past(cfg.mode) != XFER_TX_ONLY));
  // R5: loading the shifter empties the TX register.
  a_r5_load_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !wr_tx) |=> tx_empty);
  // R3: at end of transfer the serial clock rests at its idle level.
  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    eot |-> (sclk == cfg.cpol));
  // R11: the soft-reset cycle clears the channel state.
  a_r11_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (tx_empty && !rx_full && !ctrl_en && !busy));
endmodule

// File: tb/spim_channel_test.sv
`timescale 1ns/1ps
module spim_channel_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        sclk, mosi, miso, cs_out, dma_tx_req, dma_rx_req;

  int n_chk = 0, n_fail = 0;
  logic [31:0] v;

  spim_channel uut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_out(cs_out),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  always #2.5 clk = ~clk;

  // Slave model
  logic        b_pol = 1'b0, b_pha = 1'b0;
  int          b_wl = 8, exp_gap = 1;
  logic [31:0] sreg = '0, cap = '0;
  logic        first = 1'b1, seen = 1'b0, gap_bad = 1'b0, prev_sclk = 1'b0;
  int          edges = 0, cyc_gap = 0;
  logic        lead;

  assign miso = sreg[b_wl-1];

  always @(negedge clk) begin
    cyc_gap = cyc_gap + 1;
    if (sclk !== prev_sclk) begin
      edges = edges + 1;
      if (seen && cyc_gap != exp_gap) gap_bad = 1'b1;
      seen = 1'b1;
      cyc_gap = 0;
      lead = (sclk != b_pol);
      if (b_pha ? !lead : lead) cap = {cap[30:0], mosi};
      if (b_pha ? (lead && !first) : !lead) sreg = {sreg[30:0], 1'b0};
      if (lead) first = 1'b0;
    end
    prev_sclk = sclk;
  end

  task automatic slave_load(input logic [31:0] pat);
    #1;
    sreg = pat; cap = '0; first = 1'b1; seen = 1'b0;
    gap_bad = 1'b0; edges = 0; cyc_gap = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_en = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wait_stat(input logic [31:0] mask);
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(8'h30, s);
      if ((s & mask) == mask) return;
    end
    chk("status wait timeout", s & mask, mask);
  endtask

  function automatic logic [31:0] wmask(input int wl);
    return (wl >= 32) ? 32'hFFFF_FFFF : ((32'd1 << wl) - 32'd1);
  endfunction

  function automatic logic [31:0] mkcfg(input logic pol, input logic pha,
      input logic [3:0] dv, input int wl, input logic [1:0] md);
    logic [4:0] wm1;
    wm1 = 5'(wl - 1);
    return (32'd1 << 20) | (32'd1 << 6) | {18'b0, md, 12'b0} |
           {20'b0, wm1, 7'b0} | {26'b0, dv, 2'b0} | {30'b0, pol, pha};
  endfunction

  // {pol, pha, div, wl-1, tx, slave pattern}
  localparam logic [74:0] VEC [6] = '{
    {1'b0, 1'b0, 4'd0, 5'd7,  32'h0000_00A5, 32'h0000_003C},
    {1'b0, 1'b1, 4'd1, 5'd15, 32'h0000_1234, 32'h0000_BEEF},
    {1'b1, 1'b0, 4'd2, 5'd3,  32'hFFFF_FFF9, 32'hFFFF_FFF6},
    {1'b1, 1'b1, 4'd0, 5'd31, 32'hDEAD_BEEF, 32'h0F1E_2D3C},
    {1'b0, 1'b0, 4'd3, 5'd11, 32'h0000_0ABC, 32'h0000_05A5},
    {1'b1, 1'b1, 4'd1, 5'd6,  32'h0000_0055, 32'h0000_002A}
  };

  task automatic setup_mode(input logic pol, input logic pha, input logic [3:0] dv,
      input int wl, input logic [1:0] md, input logic [31:0] extra);
    b_pol = pol; b_pha = pha; b_wl = wl; exp_gap = 1 << dv;
    wr(8'h2C, mkcfg(pol, pha, dv, wl, md) | extra);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h30, v); chk("R1 status", v, 32'h6);
    rd(8'h14, v); chk("R1 sysstatus", v, 32'h1);
    rd(8'h2C, v); chk("R1 config", v, 32'h0);
    chk("R1 pins", {28'b0, sclk, cs_out, dma_tx_req, dma_rx_req}, 32'h0);

    // R12 map
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h2C, v); chk("R12 config readback", v, 32'h001F_FFFF);
    rd(8'h40, v); chk("R12 unmapped", v, 32'h0);
    wr(8'h2C, 32'h0);

    // R9 chip select
    wr(8'h2C, 32'h40);            chk("R9 low-active idle", {31'b0, cs_out}, 32'h1);
    wr(8'h2C, 32'h0010_0040);     chk("R9 low-active forced", {31'b0, cs_out}, 32'h0);
    wr(8'h2C, 32'h0010_0000);     chk("R9 high-active forced", {31'b0, cs_out}, 32'h1);

    // R6 disabled channel holds the word
    setup_mode(1'b0, 1'b0, 4'd0, 8, 2'd0, 32'h0);
    slave_load(32'h0000_0081);
    wr(8'h38, 32'h0000_00C3);
    repeat (200) @(negedge clk);
    chk("R6 no sclk edges", edges, 0);
    rd(8'h30, v); chk("R6 tx pending", v & 32'h2, 32'h0);
    wr(8'h34, 32'h1);
    wait_stat(32'h5);
    rd(8'h3C, v); chk("R6 word after enable rx", v, 32'h81);
    chk("R6 word after enable tx", cap, 32'hC3);

    // R2 R3 R4 table of words
    for (int k = 0; k < 6; k++) begin
      logic [74:0] e;
      int wl;
      e = VEC[k];
      wl = int'(e[68:64]) + 1;
      setup_mode(e[74], e[73], e[72:69], wl, 2'd0, 32'h0);
      slave_load(e[31:0]);
      wr(8'h38, e[63:32]);
      wait_stat(32'h5);
      rd(8'h3C, v);  chk($sformatf("R2 rx word %0d", k), v, e[31:0] & wmask(wl));
      chk($sformatf("R2 tx word %0d", k), cap, e[63:32] & wmask(wl));
      chk($sformatf("R3 edge count %0d", k), edges, 2 * wl);
      chk($sformatf("R3 idle level %0d", k), {31'b0, sclk}, {31'b0, e[74]});
      chk($sformatf("R4 half period %0d", k), {31'b0, gap_bad}, 32'h0);
      chk($sformatf("R9 cs active %0d", k), {31'b0, cs_out}, 32'h0);
    end

    // R10 DMA requests and R5 status flow
    setup_mode(1'b0, 1'b0, 4'd0, 8, 2'd0, 32'h0000_C000);
    chk("R10 tx req when empty", {31'b0, dma_tx_req}, 32'h1);
    slave_load(32'h0000_005A);
    wr(8'h38, 32'h0000_0011);
    chk("R10 tx req drops on write", {31'b0, dma_tx_req}, 32'h0);
    wait_stat(32'h5);
    chk("R10 rx req when full", {31'b0, dma_rx_req}, 32'h1);
    rd(8'h3C, v); chk("R5 rx data", v, 32'h5A);
    chk("R10 rx req after read", {31'b0, dma_rx_req}, 32'h0);
    rd(8'h30, v); chk("R5 rx-full cleared by read", v, 32'h6);

    // R7 transmit-only
    setup_mode(1'b0, 1'b1, 4'd0, 8, 2'd2, 32'h0);
    slave_load(32'h0000_00FF);
    wr(8'h38, 32'h0000_0066);
    wait_stat(32'h4);
    repeat (10) @(negedge clk);
    rd(8'h30, v); chk("R7 rx-full stays clear", v & 32'h1, 32'h0);
    rd(8'h3C, v); chk("R7 rx register unchanged", v, 32'h5A);
    chk("R7 word shifted out", cap, 32'h66);

    // R8 receive-only
    setup_mode(1'b0, 1'b0, 4'd0, 8, 2'd1, 32'h0);
    slave_load(32'h0000_0037);
    wr(8'h38, 32'h0);
    wait_stat(32'h1);
    chk("R8 first word edges", edges, 16);
    slave_load(32'h0000_00C8);
    rd(8'h3C, v); chk("R8 first word", v, 32'h37);
    wait_stat(32'h1);
    chk("R8 read starts word", edges, 16);
    setup_mode(1'b0, 1'b0, 4'd0, 8, 2'd0, 32'h0);
    slave_load(32'h0000_0011);
    rd(8'h3C, v); chk("R8 second word", v, 32'hC8);
    repeat (100) @(negedge clk);
    chk("R8 no extra word after switch", edges, 0);
    rd(8'h30, v); chk("R8 idle status", v, 32'h6);

    // R11 soft reset
    setup_mode(1'b1, 1'b1, 4'd2, 12, 2'd0, 32'h0);
    wr(8'h10, 32'h2);
    rd(8'h14, v); chk("R11 reset in progress", v, 32'h0);
    rd(8'h14, v); chk("R11 reset done", v, 32'h1);
    rd(8'h2C, v); chk("R11 config cleared", v, 32'h0);
    rd(8'h34, v); chk("R11 enable cleared", v, 32'h0);
    rd(8'h30, v); chk("R11 status reset", v, 32'h6);

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule